// File: doc/BRIEF.md
# Character Page RAM Write-Command Parser

This block sits behind a serial host interface that already delivers whole bytes together with start and stop conditions. It turns the byte stream into write strobes for a character page RAM. Each RAM word holds a 9-bit character code above a 4-bit attribute. A host sends one or more write groups between a start and a stop. Every group names its own target address. The address never advances by itself, so each group rewrites exactly the location it names.

There are two kinds of group, and the attribute byte tells them apart. A short group of three bytes reaches only the lowest 256 locations. A long group of four bytes carries an extra high-address byte and reaches all 1024 locations. The attribute byte packs the character-code MSB into bit 7, the group kind into bits 5:4 and the attribute into bits 3:0. The parser cannot know a long group until its third byte arrives. It therefore holds the first two bytes and decides what they mean once the attribute byte is seen. A stop in the middle of a group drops the group. An attribute byte with an unknown kind code sets a sticky error flag.

Top module: `pram_wr_parser`

## Requirements
- R1: After reset, ram_we_o, err_o, ram_addr_o and ram_wdata_o are all zero.
- R2: A short group is low-address byte, attribute byte with bits 5:4 = 2'b10, then code byte. It writes address {2'b00, low byte}.
- R3: A long group is low-address byte, high-address byte, attribute byte with bits 5:4 = 2'b11, then code byte. It writes address {high[1:0], low}. High-byte bits 7:2 are not used for the address. A high byte whose bits 5:4 are 2'b10 is taken as a short-group attribute.
- R4: The write word is {attr[7], code[7:0], attr[3:0]}. ram_we_o is high for exactly the one cycle after the clock edge that takes the code byte, and for no other byte.
- R5: After a code byte, the next byte starts a new group without a new start. Groups in one transaction may mix both kinds. Each write lands on its named address, with no increment.
- R6: A stop in the middle of a group discards it without a write. Bytes received outside a start..stop span are ignored. In the same cycle, stop beats start, and start beats a byte, so a byte in a start or stop cycle is ignored.
- R7: In a long group, an attribute byte whose bits 5:4 are not 2'b11 sets err_o. All bytes are then ignored until a stop, even across a start.
- R8: err_o stays set until reset. After a stop and a new start, groups are written normally.
- R9: A start in the middle of a group discards the partial group and begins a fresh one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start condition, one-cycle pulse |
| stop_i | input | 1 | Stop condition, one-cycle pulse |
| byte_valid_i | input | 1 | byte_i carries a received byte this cycle |
| byte_i | input | 8 | Received byte |
| ram_addr_o | output | 10 | Page RAM write address |
| ram_wdata_o | output | 13 | Page RAM write word {code[8:0], attr[3:0]} |
| ram_we_o | output | 1 | Page RAM write enable, one cycle per group |
| err_o | output | 1 | Sticky error: bad group kind seen |

## Verification
The short-group sweep visits all 256 low addresses, with an attribute and code pattern that changes with the address. This catches address bits that are swapped, stuck or taken from the wrong byte. The long-group sweep covers all 1024 addresses with zeroed upper high-byte bits. A separate case fills those upper bits, which shows that only bits 1:0 reach the address. Mixed, repeated and back-to-back groups in one transaction separate a parser that rewinds correctly from one that increments or loses byte alignment. Stops and starts in the middle of a group, stray bytes outside a transaction, and a bad kind code followed by a start separate correct discard and error handling from a parser that writes partial groups or leaves the error state too early.

// File: rtl/pram_wr_pkg.sv
package pram_wr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LO,
    ST_B1,
    ST_B2,
    ST_CODE,
    ST_ERR
  } pw_state_e;

  localparam logic [1:0] KIND_SHORT = 2'b10;
  localparam logic [1:0] KIND_LONG  = 2'b11;

  // attribute byte field positions (fixed by the byte format)
  localparam int KIND_LSB = 4;
  localparam int CC_MSB_BIT = 7;

endpackage

// File: rtl/pram_wr_seq.sv
module pram_wr_seq
  import pram_wr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       byte_valid_i,
  input  logic [1:0] kind_i,
  output logic       ld_lo_o,
  output logic       ld_hi_o,
  output logic       ld_attr_o,
  output logic       wr_go_o,
  output logic       short_o,
  output logic       err_o
);

  pw_state_e state_q, state_d;
  logic      short_q, short_d;
  logic      err_q, err_set;

  always_comb begin
    state_d   = state_q;
    short_d   = short_q;
    ld_lo_o   = 1'b0;
    ld_hi_o   = 1'b0;
    ld_attr_o = 1'b0;
    wr_go_o   = 1'b0;
    err_set   = 1'b0;
    if (stop_i) begin
      state_d = ST_IDLE;
    end else if (start_i) begin
      if (state_q != ST_ERR) state_d = ST_LO;
    end else if (byte_valid_i) begin
      unique case (state_q)
        ST_LO: begin
          ld_lo_o = 1'b1;
          state_d = ST_B1;
        end
        ST_B1: begin
          // second byte is either a short-group attribute or a high address
          if (kind_i == KIND_SHORT) begin
            ld_attr_o = 1'b1;
            short_d   = 1'b1;
            state_d   = ST_CODE;
          end else begin
            ld_hi_o = 1'b1;
            state_d = ST_B2;
          end
        end
        ST_B2: begin
          if (kind_i == KIND_LONG) begin
            ld_attr_o = 1'b1;
            short_d   = 1'b0;
            state_d   = ST_CODE;
          end else begin
            err_set = 1'b1;
            state_d = ST_ERR;
          end
        end
        ST_CODE: begin
          wr_go_o = 1'b1;
          state_d = ST_LO;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      short_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      short_q <= short_d;
      err_q   <= err_q | err_set;
    end
  end

  assign short_o = short_q;
  assign err_o   = err_q;

endmodule

// File: rtl/pram_wr_hold.sv
module pram_wr_hold #(
  parameter int BYTE_W = 8,
  parameter int HI_W   = 2,
  parameter int ATT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_lo_i,
  input  logic              ld_hi_i,
  input  logic              ld_attr_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [HI_W-1:0]   hi_o,
  output logic              cc_msb_o,
  output logic [ATT_W-1:0]  att_o
);

  logic [BYTE_W-1:0] lo_q;
  logic [HI_W-1:0]   hi_q;
  logic              cc_msb_q;
  logic [ATT_W-1:0]  att_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q     <= '0;
      hi_q     <= '0;
      cc_msb_q <= 1'b0;
      att_q    <= '0;
    end else begin
      if (ld_lo_i) lo_q <= byte_i;
      if (ld_hi_i) hi_q <= byte_i[HI_W-1:0];
      if (ld_attr_i) begin
        cc_msb_q <= byte_i[BYTE_W-1];
        att_q    <= byte_i[ATT_W-1:0];
      end
    end
  end

  assign lo_o     = lo_q;
  assign hi_o     = hi_q;
  assign cc_msb_o = cc_msb_q;
  assign att_o    = att_q;

endmodule

// File: rtl/pram_wr_out.sv
module pram_wr_out #(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 10,
  parameter int ATT_W  = 4,
  localparam int HI_W   = ADDR_W - BYTE_W,
  localparam int CODE_W = BYTE_W + 1,
  localparam int WORD_W = CODE_W + ATT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_go_i,
  input  logic              short_i,
  input  logic [BYTE_W-1:0] lo_i,
  input  logic [HI_W-1:0]   hi_i,
  input  logic              cc_msb_i,
  input  logic [ATT_W-1:0]  att_i,
  input  logic [BYTE_W-1:0] code_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WORD_W-1:0] data_o,
  output logic              we_o
);

  logic [ADDR_W-1:0] addr_sel;

  generate
    if (HI_W > 0) begin : g_hi
      always_comb begin
        if (short_i) addr_sel = {{HI_W{1'b0}}, lo_i};
        else         addr_sel = {hi_i, lo_i};
      end
    end else begin : g_flat
      assign addr_sel = lo_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      data_o <= '0;
      we_o   <= 1'b0;
    end else begin
      we_o <= wr_go_i;
      if (wr_go_i) begin
        addr_o <= addr_sel;
        data_o <= {cc_msb_i, code_i, att_i};
      end
    end
  end

endmodule

// File: rtl/pram_wr_parser.sv
module pram_wr_parser
  import pram_wr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 10,
  parameter int ATT_W  = 4,
  localparam int HI_W   = ADDR_W - BYTE_W,
  localparam int WORD_W = BYTE_W + 1 + ATT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [WORD_W-1:0] ram_wdata_o,
  output logic              ram_we_o,
  output logic              err_o
);

  logic              ld_lo, ld_hi, ld_attr, wr_go, short_q;
  logic [BYTE_W-1:0] lo_q;
  logic [HI_W-1:0]   hi_q;
  logic              cc_msb_q;
  logic [ATT_W-1:0]  att_q;

  pram_wr_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .byte_valid_i(byte_valid_i),
    .kind_i      (byte_i[KIND_LSB+1:KIND_LSB]),
    .ld_lo_o     (ld_lo),
    .ld_hi_o     (ld_hi),
    .ld_attr_o   (ld_attr),
    .wr_go_o     (wr_go),
    .short_o     (short_q),
    .err_o       (err_o)
  );

  pram_wr_hold #(.BYTE_W(BYTE_W), .HI_W(HI_W), .ATT_W(ATT_W)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_lo_i  (ld_lo),
    .ld_hi_i  (ld_hi),
    .ld_attr_i(ld_attr),
    .byte_i   (byte_i),
    .lo_o     (lo_q),
    .hi_o     (hi_q),
    .cc_msb_o (cc_msb_q),
    .att_o    (att_q)
  );

  pram_wr_out #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .ATT_W(ATT_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_go_i (wr_go),
    .short_i (short_q),
    .lo_i    (lo_q),
    .hi_i    (hi_q),
    .cc_msb_i(cc_msb_q),
    .att_i   (att_q),
    .code_i  (byte_i),
    .addr_o  (ram_addr_o),
    .data_o  (ram_wdata_o),
    .we_o    (ram_we_o)
  );

endmodule

// File: rtl/pram_wr_parser_chk.sv
module pram_wr_parser_chk #(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              stop_i,
  input logic              byte_valid_i,
  input logic              short_i,
  input logic [ADDR_W-1:0] ram_addr_o,
  input logic              ram_we_o,
  input logic              err_o
);

  // R4: write strobe is a single-cycle pulse
  a_r4_we_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |=> !ram_we_o);

  // R4/R6: a write follows only a byte taken in a cycle without start or stop
  a_r6_we_after_plain_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(byte_valid_i && !start_i && !stop_i) |=> !ram_we_o);

  // R6: stop never produces a write
  a_r6_stop_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !ram_we_o);

  // R8: error flag is sticky
  a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  // R7: error rises only on an accepted byte
  a_r7_err_on_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(byte_valid_i && !start_i && !stop_i));

  // R2: short-group writes stay in the low region
  a_r2_short_low_region: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_o && short_i) |-> (ram_addr_o[ADDR_W-1:BYTE_W] == '0));

endmodule

bind pram_wr_parser pram_wr_parser_chk #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .stop_i      (stop_i),
  .byte_valid_i(byte_valid_i),
  .short_i     (short_q),
  .ram_addr_o  (ram_addr_o),
  .ram_we_o    (ram_we_o),
  .err_o       (err_o)
);

// File: tb/pram_wr_parser_bench.sv
module pram_wr_parser_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        stop_i = 1'b0;
  logic        byte_valid_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic [9:0]  ram_addr_o;
  logic [12:0] ram_wdata_o;
  logic        ram_we_o;
  logic        err_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  pram_wr_parser u_pram_wr_parser (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .byte_valid_i(byte_valid_i),
    .byte_i      (byte_i),
    .ram_addr_o  (ram_addr_o),
    .ram_wdata_o (ram_wdata_o),
    .ram_we_o    (ram_we_o),
    .err_o       (err_o)
  );

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // all tasks are entered and left at a falling edge
  task automatic send(input logic [7:0] b);
    byte_valid_i = 1'b1;
    byte_i = b;
    @(negedge clk_i);
    byte_valid_i = 1'b0;
  endtask

  task automatic do_start();
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic do_stop();
    stop_i = 1'b1;
    @(negedge clk_i);
    stop_i = 1'b0;
  endtask

  task automatic expect_write(input string rq, input logic [9:0] a, input logic [7:0] attr,
                              input logic [7:0] code);
    check(rq, {ram_we_o, ram_addr_o, ram_wdata_o}, {1'b1, a, attr[7], code, attr[3:0]});
  endtask

  task automatic short_grp(input string rq, input logic [7:0] lo, input logic [7:0] attr,
                           input logic [7:0] code, input bit chk_we);
    send(lo);
    if (chk_we) check({rq, " no we on lo"}, ram_we_o, 0);
    send(attr);
    send(code);
    if (chk_we) expect_write(rq, {2'b00, lo}, attr, code);
  endtask

  task automatic long_grp(input string rq, input logic [7:0] lo, input logic [7:0] hi,
                          input logic [7:0] attr, input logic [7:0] code);
    send(lo);
    send(hi);
    send(attr);
    check({rq, " no we before code"}, ram_we_o, 0);
    send(code);
    expect_write(rq, {hi[1:0], lo}, attr, code);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 reset", {ram_we_o, err_o, ram_addr_o, ram_wdata_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 short sweep over all low addresses, R4 data packing
    do_start();
    for (int a = 0; a < 256; a++) begin
      logic [7:0] at, cd;
      at = {a[0], a[1], 2'b10, a[5:2] ^ a[7:4]};
      cd = 8'(a * 7 + 3);
      short_grp("R2 short sweep", 8'(a), at, cd, (a % 64) == 0);
      if ((a % 64) != 0) expect_write("R2 short sweep", 10'(a), at, cd);
    end
    @(negedge clk_i);
    check("R4 we single cycle", ram_we_o, 0);
    do_stop();

    // R3 long sweep over the whole page
    do_start();
    for (int a = 0; a < 1024; a++) begin
      logic [7:0] at, cd;
      at = {a[3], 1'b0, 2'b11, a[7:4]};
      cd = 8'((a & 8'hff) ^ 8'h5a) + 8'(a >> 8);
      long_grp("R3 long sweep", 8'(a), {6'b0, 2'(a >> 8)}, at, cd);
    end
    // R3 upper high-byte bits ignored for the address (bits 5:4 = 00)
    long_grp("R3 high upper bits", 8'h3c, 8'hce, 8'hb9, 8'h81);
    do_stop();

    // R5 mixed kinds, repeated address, no increment, no new start
    do_start();
    short_grp("R5 mixed short", 8'h05, 8'h2a, 8'h11, 1'b1);
    long_grp("R5 mixed long", 8'h05, 8'h03, 8'hb1, 8'h22);
    long_grp("R5 same addr again", 8'h05, 8'h03, 8'h32, 8'h23);
    short_grp("R5 short after long", 8'hff, 8'ha7, 8'h44, 1'b1);
    do_stop();

    // R6 stop mid-group discards; later bytes outside a transaction ignored
    do_start();
    send(8'h40);
    send(8'h2f);
    do_stop();
    send(8'h99);
    check("R6 stop mid-group", ram_we_o, 0);
    send(8'h41);
    send(8'h2f);
    send(8'h99);
    check("R6 bytes outside transaction", ram_we_o, 0);
    // R6 byte in a start cycle is ignored
    start_i = 1'b1; byte_valid_i = 1'b1; byte_i = 8'h77;
    @(negedge clk_i);
    start_i = 1'b0; byte_valid_i = 1'b0;
    short_grp("R6 byte with start ignored", 8'h12, 8'h23, 8'h34, 1'b1);
    do_stop();

    // R9 start mid-group restarts the group
    do_start();
    send(8'h11);
    send(8'h2e);
    do_start();
    short_grp("R9 restart", 8'h33, 8'h25, 8'h66, 1'b1);
    do_stop();
    check("R8 no error yet", err_o, 0);

    // R7 bad kind code in a long group
    do_start();
    send(8'h50);
    send(8'h01);
    send(8'h15);
    check("R7 error raised", err_o, 1);
    short_grp("R7 ignored after error", 8'h60, 8'h21, 8'h70, 1'b0);
    check("R7 no write in error", ram_we_o, 0);
    do_start();
    short_grp("R7 start keeps ignoring", 8'h61, 8'h21, 8'h71, 1'b0);
    check("R7 no write after start in error", ram_we_o, 0);
    do_stop();
    // R8 sticky error, normal writes resume
    do_start();
    short_grp("R8 resume after stop", 8'h62, 8'h2c, 8'h72, 1'b1);
    check("R8 error sticky", err_o, 1);
    do_stop();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule